// File: doc/BRIEF.md
# Combining Prefix-Sum Register Unit

A shared unit that holds a small bank of prefix-sum registers for many thread control units. In every clock cycle each of `N_REQ` requester slots may present one request. A request names a register, an operation and, for a set, a load value. All requests that target the same register in the same cycle are combined into one multi-operand prefix-sum. Each requester gets its own prior value, and the register moves on by the group total. Requests to different registers are handled side by side in the same cycle.

Each register keeps two counts. The allocated count is the next value to hand out. The committed count is the value that other requesters can see. Increment draws a value and makes it visible at once. Allocate draws a value but keeps it hidden until a matching commit. Read returns the visible count. Set loads a new value serially, and set takes priority over every other request to that register in the same cycle.

Results come back through a two-stage pipeline. Each response slot carries a valid bit, the requester index and the returned value, and it appears a fixed number of cycles after the request.

Top module: `psu_top`

## Requirements
- R1: After a synchronous reset, every register has committed and allocated counts of zero, and no response slot is valid.
- R2: A request is presented in the cycle before clock edge k. Its response is valid in the same slot after edge k+1. The response carries `rsp_tag` equal to the slot index. Opcode 0 (no-op) gives no response.
- R3: Increment (opcode 1) returns the allocated count plus the number of lower-indexed increment or allocate requests to the same register in that cycle. Both counts advance by the number of increments, and the allocated count also advances by the number of allocates.
- R4: Read (opcode 2) returns the committed count and changes nothing.
- R5: Set (opcode 3) loads its data into both counts. If several sets hit one register in the same cycle, the lowest-indexed one wins. Every set returns the committed count from before the cycle. All other same-cycle requests to that register use the loaded value as their base.
- R6: Allocate (opcode 4) draws a value the same way an increment does, but it leaves the committed count unchanged, so a later read does not see it.
- R7: Commit (opcode 5) returns the committed count plus the number of lower-indexed commits to that register in the cycle. The committed count advances by the number of commits, but it never rises above the allocated count.
- R8: In one group, all increment and allocate requests receive pairwise distinct values.
- R9: Requests to different registers in the same cycle do not affect one another.
- R10: Requests in consecutive cycles are serialized. The later cycle sees the register state that the earlier cycle produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | N_REQ*3 | Opcode per slot, slot 0 in the low bits |
| req_reg | input | N_REQ*REG_W | Target register index per slot |
| req_data | input | N_REQ*DATA_W | Load value per slot, used by set |
| rsp_valid | output | N_REQ | Response valid per slot |
| rsp_tag | output | N_REQ*TAG_W | Requester index per slot |
| rsp_value | output | N_REQ*DATA_W | Returned prior value per slot |

## Verification
The hardest case to reach is a single cycle where a set, increments, allocates and commits all meet on one register. In that case the set base, the prefix ranks and the clip of the committed count all interact. The stimulus table drives such cycles directly: two competing sets with an increment and an allocate, then a commit burst that is larger than the number of outstanding allocations, so the clip at the allocated count takes effect. Back-to-back cycles on one register then check that the state passes from one cycle to the next.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_INC    = 3'd1,
    OP_READ   = 3'd2,
    OP_SET    = 3'd3,
    OP_ALLOC  = 3'd4,
    OP_COMMIT = 3'd5
  } psu_op_e;

  localparam int OP_W = 3;

  // Operations that draw a fresh value from the allocated count.
  function automatic logic op_draws(psu_op_e op);
    return (op == OP_INC) || (op == OP_ALLOC);
  endfunction

endpackage

// File: rtl/psu_capture.sv
module psu_capture
  import psu_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int REG_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ*OP_W-1:0]   req_op,
  input  logic [N_REQ*REG_W-1:0]  req_reg,
  input  logic [N_REQ*DATA_W-1:0] req_data,
  output psu_op_e                 s1_op   [N_REQ],
  output logic [REG_W-1:0]        s1_reg  [N_REQ],
  output logic [DATA_W-1:0]       s1_data [N_REQ]
);

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_op[i]   <= OP_NOP;
        s1_reg[i]  <= '0;
        s1_data[i] <= '0;
      end else begin
        s1_op[i]   <= psu_op_e'(req_op[i*OP_W +: OP_W]);
        s1_reg[i]  <= req_reg[i*REG_W +: REG_W];
        s1_data[i] <= req_data[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/psu_reg_lane.sv
module psu_reg_lane
  import psu_pkg::*;
#(
  parameter int N_REQ   = 4,
  parameter int REG_W   = 2,
  parameter int DATA_W  = 16,
  parameter int LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  psu_op_e           s1_op   [N_REQ],
  input  logic [REG_W-1:0]  s1_reg  [N_REQ],
  input  logic [DATA_W-1:0] s1_data [N_REQ],
  output logic [DATA_W-1:0] ret     [N_REQ]
);

  localparam int CNT_W = $clog2(N_REQ + 1);

  logic [DATA_W-1:0] com_q, alc_q;
  logic [DATA_W-1:0] base_c, base_a, set_val;
  logic [DATA_W-1:0] c_sum, c_next, a_next;
  logic              set_hit;
  logic [CNT_W-1:0]  draw_n, inc_n, cmt_n;
  logic [N_REQ-1:0]  hit;

  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      hit[i] = (s1_reg[i] == REG_W'(LANE_ID)) && (s1_op[i] != OP_NOP);
    end
    // Lowest-indexed set wins: scan downward so lower slots overwrite.
    set_hit = 1'b0;
    set_val = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (hit[i] && s1_op[i] == OP_SET) begin
        set_hit = 1'b1;
        set_val = s1_data[i];
      end
    end
    base_c = set_hit ? set_val : com_q;
    base_a = set_hit ? set_val : alc_q;
    draw_n = '0;
    inc_n  = '0;
    cmt_n  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      ret[i] = '0;
      if (hit[i]) begin
        case (s1_op[i])
          OP_INC: begin
            ret[i] = base_a + DATA_W'(draw_n);
            draw_n = draw_n + CNT_W'(1);
            inc_n  = inc_n + CNT_W'(1);
          end
          OP_ALLOC: begin
            ret[i] = base_a + DATA_W'(draw_n);
            draw_n = draw_n + CNT_W'(1);
          end
          OP_READ:   ret[i] = base_c;
          OP_COMMIT: begin
            ret[i] = base_c + DATA_W'(cmt_n);
            cmt_n  = cmt_n + CNT_W'(1);
          end
          OP_SET:    ret[i] = com_q;
          default:   ret[i] = '0;
        endcase
      end
    end
    a_next = base_a + DATA_W'(draw_n);
    c_sum  = base_c + DATA_W'(inc_n) + DATA_W'(cmt_n);
    c_next = (c_sum > a_next) ? a_next : c_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_q <= '0;
      alc_q <= '0;
    end else begin
      com_q <= c_next;
      alc_q <= a_next;
    end
  end

  // R7: visible count never runs ahead of the allocation count
  a_r7_commit_bound: assert property (@(posedge clk) disable iff (rst)
    com_q <= alc_q);

  // R3/R6: without a set, the allocation count never moves backward
  a_r3_alloc_monotone: assert property (@(posedge clk) disable iff (rst)
    !set_hit |=> alc_q >= $past(alc_q));

endmodule

// File: rtl/psu_top.sv
module psu_top
  import psu_pkg::*;
#(
  parameter  int N_REQ  = 4,
  parameter  int N_PREG = 4,
  parameter  int DATA_W = 16,
  localparam int REG_W  = (N_PREG > 1) ? $clog2(N_PREG) : 1,
  localparam int TAG_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ*OP_W-1:0]   req_op,
  input  logic [N_REQ*REG_W-1:0]  req_reg,
  input  logic [N_REQ*DATA_W-1:0] req_data,
  output logic [N_REQ-1:0]        rsp_valid,
  output logic [N_REQ*TAG_W-1:0]  rsp_tag,
  output logic [N_REQ*DATA_W-1:0] rsp_value
);

  psu_op_e           s1_op   [N_REQ];
  logic [REG_W-1:0]  s1_reg  [N_REQ];
  logic [DATA_W-1:0] s1_data [N_REQ];
  logic [DATA_W-1:0] lane_ret [N_PREG][N_REQ];
  logic [DATA_W-1:0] sel_val  [N_REQ];

  logic [DATA_W-1:0] val_q  [N_REQ];
  logic [REG_W-1:0]  reg_q  [N_REQ];
  logic [N_REQ-1:0]  vld_q, draw_q;

  psu_capture #(
    .N_REQ (N_REQ),
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) i_capture (
    .clk     (clk),
    .rst     (rst),
    .req_op  (req_op),
    .req_reg (req_reg),
    .req_data(req_data),
    .s1_op   (s1_op),
    .s1_reg  (s1_reg),
    .s1_data (s1_data)
  );

  for (genvar g = 0; g < N_PREG; g++) begin : g_lane
    psu_reg_lane #(
      .N_REQ  (N_REQ),
      .REG_W  (REG_W),
      .DATA_W (DATA_W),
      .LANE_ID(g)
    ) i_lane (
      .clk    (clk),
      .rst    (rst),
      .s1_op  (s1_op),
      .s1_reg (s1_reg),
      .s1_data(s1_data),
      .ret    (lane_ret[g])
    );
  end

  // Route each slot's result from the lane it addressed.
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      sel_val[i] = '0;
      for (int g = 0; g < N_PREG; g++) begin
        if (s1_reg[i] == REG_W'(g)) sel_val[i] = lane_ret[g][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      draw_q <= '0;
      for (int i = 0; i < N_REQ; i++) begin
        val_q[i] <= '0;
        reg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_REQ; i++) begin
        vld_q[i]  <= (s1_op[i] != OP_NOP);
        draw_q[i] <= op_draws(s1_op[i]);
        val_q[i]  <= sel_val[i];
        reg_q[i]  <= s1_reg[i];
      end
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_out
    assign rsp_valid[i]                 = vld_q[i];
    assign rsp_tag[i*TAG_W +: TAG_W]    = TAG_W'(i);
    assign rsp_value[i*DATA_W +: DATA_W] = val_q[i];

    // R2: a response appears exactly one edge after the captured request
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      vld_q[i] == $past(s1_op[i] != OP_NOP));

    for (genvar j = i + 1; j < N_REQ; j++) begin : g_pair
      // R8: drawers in one group never share a returned value
      a_r8_distinct: assert property (@(posedge clk) disable iff (rst)
        (vld_q[i] && vld_q[j] && draw_q[i] && draw_q[j] && reg_q[i] == reg_q[j])
          |-> val_q[i] != val_q[j]);
    end
  end

endmodule

// File: tb/test_psu_top.sv
module test_psu_top;

  localparam int N      = 4;
  localparam int DW     = 16;
  localparam int RW     = 2;
  localparam int TW     = 2;
  localparam int NV     = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*3-1:0]  req_op   = '0;
  logic [N*RW-1:0] req_reg  = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]    rsp_valid;
  logic [N*TW-1:0] rsp_tag;
  logic [N*DW-1:0] rsp_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  psu_top #(.N_REQ(N), .N_PREG(4), .DATA_W(DW)) i_psu_top (
    .clk      (clk),
    .rst      (rst),
    .req_op   (req_op),
    .req_reg  (req_reg),
    .req_data (req_data),
    .rsp_valid(rsp_valid),
    .rsp_tag  (rsp_tag),
    .rsp_value(rsp_value)
  );

  // Slot 3 leftmost in every concatenation. Opcodes: 1 inc, 2 read, 3 set, 4 alloc, 5 commit.
  localparam logic [11:0] T_OP [NV] = '{
    {3'd1, 3'd1, 3'd1, 3'd1},
    {3'd1, 3'd1, 3'd1, 3'd2},
    {3'd3, 3'd2, 3'd3, 3'd1},
    {3'd2, 3'd4, 3'd4, 3'd4},
    {3'd1, 3'd5, 3'd5, 3'd2},
    {3'd5, 3'd5, 3'd5, 3'd2},
    {3'd2, 3'd2, 3'd0, 3'd2},
    {3'd3, 3'd4, 3'd1, 3'd3},
    {3'd1, 3'd2, 3'd5, 3'd2},
    {3'd0, 3'd0, 3'd2, 3'd2}
  };
  localparam logic [7:0] T_REG [NV] = '{
    {2'd0, 2'd0, 2'd0, 2'd0},
    {2'd1, 2'd0, 2'd1, 2'd0},
    {2'd2, 2'd2, 2'd2, 2'd2},
    {2'd3, 2'd3, 2'd3, 2'd3},
    {2'd3, 2'd3, 2'd3, 2'd3},
    {2'd3, 2'd3, 2'd3, 2'd3},
    {2'd0, 2'd1, 2'd0, 2'd3},
    {2'd0, 2'd0, 2'd0, 2'd0},
    {2'd2, 2'd2, 2'd0, 2'd0},
    {2'd0, 2'd0, 2'd2, 2'd0}
  };
  localparam logic [63:0] T_DATA [NV] = '{
    64'd0, 64'd0,
    {16'd200, 16'd0, 16'd100, 16'd0},
    64'd0, 64'd0, 64'd0, 64'd0,
    {16'd9, 16'd0, 16'd0, 16'd7},
    64'd0, 64'd0
  };
  localparam logic [63:0] T_EXP [NV] = '{
    {16'd3,   16'd2,   16'd1,   16'd0},
    {16'd1,   16'd4,   16'd0,   16'd4},
    {16'd0,   16'd100, 16'd0,   16'd100},
    {16'd0,   16'd2,   16'd1,   16'd0},
    {16'd3,   16'd1,   16'd0,   16'd0},
    {16'd5,   16'd4,   16'd3,   16'd3},
    {16'd5,   16'd2,   16'd0,   16'd4},
    {16'd5,   16'd8,   16'd7,   16'd5},
    {16'd101, 16'd101, 16'd8,   16'd8},
    {16'd0,   16'd0,   16'd102, 16'd9}
  };
  localparam string T_TAG [NV] = '{
    "R3 R8", "R4 R9 R3", "R5", "R6 R8 R4", "R7 R6",
    "R7 clip", "R2 R4 R9", "R5 R3 R6", "R7 R9", "R4 R2"
  };

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] op, logic [7:0] rg, logic [63:0] dt);
    req_op   = op;
    req_reg  = rg;
    req_data = dt;
  endtask

  task automatic check_slots(string tag, logic [11:0] op, logic [63:0] exp);
    for (int s = 0; s < N; s++) begin
      logic v_exp;
      v_exp = (op[s*3 +: 3] != 3'd0);
      check({tag, " R2 valid"}, DW'(rsp_valid[s]), DW'(v_exp));
      if (v_exp) begin
        check({tag, " R2 tag"}, DW'(rsp_tag[s*TW +: TW]), DW'(s));
        check(tag, rsp_value[s*DW +: DW], exp[s*DW +: DW]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle after reset
    check("R1 idle", DW'(rsp_valid), '0);

    // Stimulus table: one request cycle, then result two edges later.
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(T_OP[k], T_REG[k], T_DATA[k]);
      @(negedge clk);
      drive('0, '0, '0);
      @(negedge clk);
      check_slots(T_TAG[k], T_OP[k], T_EXP[k]);
    end

    // R10: back-to-back increments on register 1 (count is 2)
    @(negedge clk);
    drive({3'd0, 3'd0, 3'd0, 3'd1}, {2'd0, 2'd0, 2'd0, 2'd1}, '0);
    @(negedge clk);
    drive({3'd0, 3'd0, 3'd0, 3'd1}, {2'd0, 2'd0, 2'd0, 2'd1}, '0);
    @(negedge clk);
    drive('0, '0, '0);
    check("R10 first", rsp_value[DW-1:0], 16'd2);
    @(negedge clk);
    check("R10 second", rsp_value[DW-1:0], 16'd3);
    check("R10 single valid", DW'(rsp_valid), 16'd1);

    // R1: reset mid-traffic clears state and responses
    @(negedge clk);
    drive({3'd1, 3'd1, 3'd1, 3'd1}, '0, '0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    drive('0, '0, '0);
    rst = 1'b0;
    check("R1 valid after reset", DW'(rsp_valid), '0);
    @(negedge clk);
    drive({3'd0, 3'd2, 3'd2, 3'd2}, {2'd0, 2'd3, 2'd2, 2'd0}, '0);
    @(negedge clk);
    drive('0, '0, '0);
    @(negedge clk);
    check("R1 reg0 cleared", rsp_value[0 +: DW], 16'd0);
    check("R1 reg2 cleared", rsp_value[DW +: DW], 16'd0);
    check("R1 reg3 cleared", rsp_value[2*DW +: DW], 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule